// File: doc/BRIEF.md
# Register-Driven SPI Flash Command Engine

This block is an SPI master that carries out a single serial-flash command at a time under control of a small byte-wide register file. Software places an opcode and a packed pair of byte counts in two registers. It loads the outgoing payload bytes into an eight-slot byte store through a data port that advances its own pointer. Writing the start bit then launches the command.

The engine lowers chip select and shifts out the opcode followed by the payload bytes, most significant bit first, in SPI mode 0. It then clocks in the requested number of reply bytes while holding MOSI low. The reply bytes are deposited in the same store, in the slots that follow the payload. The start bit reads back as 1 until the last bit has been exchanged and clears by itself.

Software then rewinds the pointer and reads the payload and the reply back through the data port. A command with both counts at zero sends only its opcode, which suits single-byte flash instructions such as write enable or chip erase.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the opcode (offset 0x0), count (0x1), control (0x2) and pointer (0xD) registers read 0x00; chip select is high, SCK is low and MOSI is low.
- R2: Offset 0x0 holds the opcode and offset 0x1 holds the counts: bits 3:0 give the payload (transmit) byte count and bits 7:4 give the reply (receive) byte count. Both registers read back what was written while idle.
- R3: Writing a value with bit 0 set to offset 0x2 while idle starts a command. Bit 0 of offset 0x2 reads 1 from the next cycle until the command completes, and then reads 0 on its own.
- R4: Writing a value with bit 4 set to offset 0x2 while idle sets the store pointer to 0. The pointer reads back in bits 2:0 of offset 0xD, and the upper bits read 0.
- R5: A write to offset 0xC stores the byte at the pointer and a read of 0xC returns the byte at the pointer; both advance the pointer by one, modulo 8.
- R6: A command shifts the opcode first and then the payload from slots 0 upward, MSB first, in mode 0. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising edge. Each SCK period is 2*CLK_DIV system clocks, including across byte boundaries.
- R7: Reply bytes are written to slots starting at the transmit count modulo 8, wrapping modulo 8, whatever the pointer held before. MOSI is low during reply bytes, and the pointer ends at (transmit + receive) modulo 8.
- R8: With both counts zero only the opcode is sent: exactly 8 SCK pulses.
- R9: Chip select is low for the whole command and returns high in the cycle in which bit 0 of offset 0x2 clears.
- R10: While a command runs, writes to offsets 0x0, 0x1, 0x2 and 0xC, and reads of 0xC, change no register, stored byte or the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe, advances the pointer on offset 0xC |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, valid in the same cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A wrong sequencer phase or byte counter shows at the serial pins within one byte time, at most 16*CLK_DIV cycles. It appears as a missing or extra group of eight SCK pulses, or as a payload byte shifted out of order. A wrong pointer load at the switch into the reply phase stays hidden during the command. It appears when the pointer register is read after completion and when the store is read back, because each reply byte then sits in the wrong slot. A bit-sampling error on the wrong SCK edge corrupts every reply byte by one bit position, so the first read-back slot exposes it.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
   localparam int BYTE_W = 8;
   localparam int CNT_W  = 4;
   localparam logic [3:0] OFS_OPC  = 4'h0;
   localparam logic [3:0] OFS_CNT  = 4'h1;
   localparam logic [3:0] OFS_CTL  = 4'h2;
   localparam logic [3:0] OFS_DATA = 4'hC;
   localparam logic [3:0] OFS_PTR  = 4'hD;
   localparam int CTL_GO_BIT  = 0;
   localparam int CTL_RST_BIT = 4;
   typedef enum logic [1:0] {PH_IDLE, PH_OPC, PH_TX, PH_RX} phase_e;
endpackage

// File: rtl/spi_cmd_fifo.sv
`timescale 1ns/1ps
module spi_cmd_fifo #(
   parameter int DEPTH = 8,
   parameter int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_clr,
   input  logic             ptr_load,
   input  logic [PTR_W-1:0] load_val,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             adv,
   output logic [7:0]       rd_data,
   output logic [PTR_W-1:0] ptr
);
   generate
      if ((DEPTH < 2) || (DEPTH > 16) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("spi_cmd_fifo: DEPTH must be a power of two from 2 to 16");
      end
   endgenerate

   logic [DEPTH-1:0][7:0] slot_q;
   logic [PTR_W-1:0]      ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (ptr_q == PTR_W'(i)) slot_q[i] <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= '0;
      else if (ptr_clr)  ptr_q <= '0;
      else if (ptr_load) ptr_q <= load_val;
      else if (adv)      ptr_q <= ptr_q + 1'b1;
   end

   assign rd_data = slot_q[ptr_q];
   assign ptr     = ptr_q;
endmodule

// File: rtl/spi_cmd_shifter.sv
`timescale 1ns/1ps
module spi_cmd_shifter #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       done,
   output logic [7:0] rx_byte
);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("spi_cmd_shifter: CLK_DIV must be at least 1");
      end
   endgenerate

   logic       active_q;
   logic       sck_q;
   logic [2:0] bit_q;
   logic [7:0] tx_sh_q;
   logic [7:0] rx_sh_q;
   logic       tick;

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               div_q <= '0;
            else if (start)           div_q <= '0;
            else if (!active_q)       div_q <= '0;
            else if (div_q == DIV_W'(CLK_DIV - 1)) div_q <= '0;
            else                      div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_W'(CLK_DIV - 1));
      end
   endgenerate

   assign done = active_q && tick && sck_q && (bit_q == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sck_q    <= 1'b0;
         bit_q    <= '0;
         tx_sh_q  <= '0;
         rx_sh_q  <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         sck_q    <= 1'b0;
         bit_q    <= '0;
         tx_sh_q  <= tx_byte;
      end else if (active_q && tick) begin
         if (!sck_q) begin
            sck_q   <= 1'b1;
            rx_sh_q <= {rx_sh_q[6:0], miso};
         end else begin
            sck_q   <= 1'b0;
            tx_sh_q <= {tx_sh_q[6:0], 1'b0};
            bit_q   <= bit_q + 1'b1;
            if (bit_q == 3'd7) active_q <= 1'b0;
         end
      end
   end

   assign sck     = sck_q;
   assign mosi    = tx_sh_q[7];
   assign rx_byte = rx_sh_q;

   AST_MOSI_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_q) |-> $stable(mosi)) else $error("mosi moved on rising sck"); // R6
endmodule

// File: rtl/spi_cmd_seq.sv
`timescale 1ns/1ps
module spi_cmd_seq
   import spi_cmd_pkg::*;
#(
   parameter int PTR_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [7:0]       opc,
   input  logic [CNT_W-1:0] tx_n,
   input  logic [CNT_W-1:0] rx_n,
   input  logic             sh_done,
   input  logic [7:0]       sh_rx,
   input  logic [7:0]       fifo_rd,
   output logic             busy,
   output phase_e           phase,
   output logic             sh_start,
   output logic [7:0]       sh_tx,
   output logic             f_clr,
   output logic             f_load,
   output logic [PTR_W-1:0] f_load_val,
   output logic             f_wr,
   output logic [7:0]       f_wdata,
   output logic             f_adv
);
   phase_e           phase_q;
   logic [CNT_W-1:0] tx_left_q, rx_left_q, tx_total_q;
   logic             more_tx;
   logic [CNT_W-1:0] rx_after;

   assign more_tx  = ((phase_q == PH_OPC) || (phase_q == PH_TX)) && (tx_left_q != '0);
   assign rx_after = (phase_q == PH_RX) ? (rx_left_q - 1'b1) : rx_left_q;

   always_comb begin
      sh_start   = 1'b0;
      sh_tx      = '0;
      f_clr      = 1'b0;
      f_load     = 1'b0;
      f_load_val = PTR_W'(tx_total_q);
      f_wr       = 1'b0;
      f_wdata    = sh_rx;
      f_adv      = 1'b0;
      if (go) begin
         sh_start = 1'b1;
         sh_tx    = opc;
         f_clr    = 1'b1;
      end else if (sh_done) begin
         if (phase_q == PH_RX) begin
            f_wr  = 1'b1;
            f_adv = 1'b1;
         end
         if (more_tx) begin
            sh_start = 1'b1;
            sh_tx    = fifo_rd;
            f_adv    = 1'b1;
         end else if (rx_after != '0) begin
            sh_start = 1'b1;
            if (phase_q != PH_RX) f_load = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         tx_left_q  <= '0;
         rx_left_q  <= '0;
         tx_total_q <= '0;
      end else if (go) begin
         phase_q    <= PH_OPC;
         tx_left_q  <= tx_n;
         rx_left_q  <= rx_n;
         tx_total_q <= tx_n;
      end else if (sh_done) begin
         rx_left_q <= rx_after;
         if (more_tx) begin
            tx_left_q <= tx_left_q - 1'b1;
            phase_q   <= PH_TX;
         end else if (rx_after != '0) begin
            phase_q <= PH_RX;
         end else begin
            phase_q <= PH_IDLE;
         end
      end
   end

   assign busy  = (phase_q != PH_IDLE);
   assign phase = phase_q;
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int CLK_DIV    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       spi_cs_n,
   output logic       spi_sck,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int PTR_W = $clog2(FIFO_DEPTH);

   logic [7:0]       opc_q, cnt_q;
   logic             busy, wr_ok, go, bus_clr, bus_fwr, bus_adv;
   phase_e           phase;
   logic             sh_start, sh_done;
   logic [7:0]       sh_tx, sh_rx, fifo_rd;
   logic             s_clr, s_load, s_wr, s_adv;
   logic [PTR_W-1:0] s_load_val, ptr;
   logic [7:0]       s_wdata;

   assign wr_ok   = reg_wr && !busy;
   assign go      = wr_ok && (reg_addr == OFS_CTL) && reg_wdata[CTL_GO_BIT];
   assign bus_clr = wr_ok && (reg_addr == OFS_CTL) && reg_wdata[CTL_RST_BIT];
   assign bus_fwr = wr_ok && (reg_addr == OFS_DATA);
   assign bus_adv = bus_fwr || (reg_rd && !busy && (reg_addr == OFS_DATA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opc_q <= '0;
         cnt_q <= '0;
      end else if (wr_ok) begin
         if (reg_addr == OFS_OPC) opc_q <= reg_wdata;
         if (reg_addr == OFS_CNT) cnt_q <= reg_wdata;
      end
   end

   spi_cmd_seq #(.PTR_W(PTR_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .go(go), .opc(opc_q),
      .tx_n(cnt_q[CNT_W-1:0]), .rx_n(cnt_q[2*CNT_W-1:CNT_W]),
      .sh_done(sh_done), .sh_rx(sh_rx), .fifo_rd(fifo_rd),
      .busy(busy), .phase(phase), .sh_start(sh_start), .sh_tx(sh_tx),
      .f_clr(s_clr), .f_load(s_load), .f_load_val(s_load_val),
      .f_wr(s_wr), .f_wdata(s_wdata), .f_adv(s_adv)
   );

   spi_cmd_fifo #(.DEPTH(FIFO_DEPTH), .PTR_W(PTR_W)) fifo_i (
      .clk(clk), .rst_n(rst_n),
      .ptr_clr(s_clr || bus_clr), .ptr_load(s_load), .load_val(s_load_val),
      .wr_en(s_wr || bus_fwr), .wr_data(busy ? s_wdata : reg_wdata),
      .adv(s_adv || bus_adv), .rd_data(fifo_rd), .ptr(ptr)
   );

   spi_cmd_shifter #(.CLK_DIV(CLK_DIV)) shf_i (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx),
      .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
      .done(sh_done), .rx_byte(sh_rx)
   );

   assign spi_cs_n = !busy;

   always_comb begin
      case (reg_addr)
         OFS_OPC:  reg_rdata = opc_q;
         OFS_CNT:  reg_rdata = cnt_q;
         OFS_CTL:  reg_rdata = {7'b0, busy};
         OFS_DATA: reg_rdata = fifo_rd;
         OFS_PTR:  reg_rdata = {{(8-PTR_W){1'b0}}, ptr};
         default:  reg_rdata = '0;
      endcase
   end

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !spi_sck) else $error("sck high while idle"); // R6
   AST_RX_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RX) |-> !spi_mosi) else $error("mosi high in reply phase"); // R7
   AST_BUSY_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (busy && !spi_cs_n)) else $error("start not taken"); // R3
   AST_OPC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && (reg_addr == OFS_OPC)) |=> $stable(opc_q)) else $error("opcode changed while busy"); // R10
endmodule

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
   localparam int CLK_DIV = 2;
   localparam logic [3:0] A_OPC = 4'h0, A_CNT = 4'h1, A_CTL = 4'h2, A_DAT = 4'hC, A_PTR = 4'hD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] reg_addr = '0;
   logic reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_wdata = '0, reg_rdata;
   logic spi_cs_n, spi_sck, spi_mosi, spi_miso;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   spi_cmd_engine #(.FIFO_DEPTH(8), .CLK_DIV(CLK_DIV)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
      .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // flash-side model
   logic [7:0] seed = 8'h00;
   logic [7:0] s_cap = '0, s_out = '0;
   logic [7:0] mlog [16];
   int s_bit = 0, s_byte = 0, sck_bad = 0;
   time last_rise = 0;
   bit rise_ok = 1'b0;
   logic sck_d = 1'b0, cs_d = 1'b1;

   function automatic logic [7:0] resp(input int k, input logic [7:0] sd);
      return 8'((k * 29) ^ sd ^ 8'h5A);
   endfunction

   always @(spi_sck or spi_cs_n) begin
      if (cs_d === 1'b1 && spi_cs_n === 1'b0) begin
         s_bit = 0; s_byte = 0; s_out = resp(0, seed); rise_ok = 1'b0;
      end else if (spi_cs_n === 1'b0 && spi_sck === 1'b1 && sck_d === 1'b0) begin
         if (rise_ok && (($time - last_rise) != time'(2 * CLK_DIV * 10))) sck_bad++;
         last_rise = $time; rise_ok = 1'b1;
         s_cap = {s_cap[6:0], spi_mosi};
         s_bit++;
         if (s_bit == 8) begin
            if (s_byte < 16) mlog[s_byte] = s_cap;
            s_byte++; s_bit = 0;
         end
      end else if (spi_cs_n === 1'b0 && spi_sck === 1'b0 && sck_d === 1'b1) begin
         if (s_bit == 0) s_out = resp(s_byte, seed);
         else s_out = {s_out[6:0], 1'b0};
      end
      sck_d = spi_sck; cs_d = spi_cs_n;
   end
   assign spi_miso = s_out[7];

   logic [7:0] shadow [8];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   function automatic logic [7:0] dat(input int k, input int tx, input int rx);
      return 8'(k * 37 + tx * 11 + rx * 97 + 3);
   endfunction

   task automatic check_store(input string tag);
      logic [7:0] v;
      wr(A_CTL, 8'h10);
      for (int i = 0; i < 8; i++) begin
         rd(A_DAT, v);
         chk(tag, v, shadow[i]);
      end
   endtask

   task automatic run_cmd(input logic [7:0] op, input int tx, input int rx,
                          input bit rewind, input bit meddle);
      logic [7:0] v;
      int i;
      if (rewind) wr(A_CTL, 8'h10);
      for (int k = 0; k < tx; k++) begin
         wr(A_DAT, dat(k, tx, rx));
         shadow[k] = dat(k, tx, rx);
      end
      wr(A_CNT, 8'((rx << 4) | tx));
      wr(A_OPC, op);
      seed = 8'(op + tx * 16 + rx);
      wr(A_CTL, 8'h01);
      rd(A_CTL, v);
      chk("R3 busy reads 1", v, 8'h01);
      chk("R9 cs low while busy", spi_cs_n, 1'b0);
      if (meddle) begin
         wr(A_OPC, 8'h11);
         wr(A_CNT, 8'h77);
         wr(A_DAT, 8'hEE);
         wr(A_CTL, 8'h10);
         rd(A_DAT, v);
      end
      for (i = 0; i < 3000; i++) begin
         rd(A_CTL, v);
         if (!v[0]) break;
      end
      chk("R3 busy clears", (i < 3000) ? 1 : 0, 1);
      chk("R9 cs high when done", spi_cs_n, 1'b1);
      chk("R6 sck period", sck_bad, 0);
      chk((tx == 0 && rx == 0) ? "R8 opcode-only byte count" : "R6 byte count", s_byte, 1 + tx + rx);
      chk("R6 leftover bits", s_bit, 0);
      chk("R6 opcode first", mlog[0], op);
      for (int k = 0; k < tx; k++) chk("R6 payload byte", mlog[1 + k], dat(k, tx, rx));
      for (int j = 0; j < rx; j++) begin
         chk("R7 mosi low in reply", mlog[1 + tx + j], 8'h00);
         shadow[(tx + j) % 8] = resp(1 + tx + j, seed);
      end
      rd(A_PTR, v);
      chk("R7 pointer at end", v, 8'((tx + rx) % 8));
      if (meddle) begin
         rd(A_OPC, v); chk("R10 opcode kept", v, op);
         rd(A_CNT, v); chk("R10 count kept", v, 8'((rx << 4) | tx));
      end
      check_store((rx != 0) ? "R7 store after command" : "R5 store after command");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      for (int i = 0; i < 8; i++) shadow[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      rd(A_OPC, v); chk("R1 opcode reset", v, 8'h00);
      rd(A_CNT, v); chk("R1 count reset", v, 8'h00);
      rd(A_CTL, v); chk("R1 control reset", v, 8'h00);
      rd(A_PTR, v); chk("R1 pointer reset", v, 8'h00);
      chk("R1 cs high", spi_cs_n, 1'b1);
      chk("R1 sck low", spi_sck, 1'b0);
      chk("R1 mosi low", spi_mosi, 1'b0);

      wr(A_OPC, 8'hA3); rd(A_OPC, v); chk("R2 opcode readback", v, 8'hA3);
      wr(A_CNT, 8'h52); rd(A_CNT, v); chk("R2 count readback", v, 8'h52);

      // R5 wrap and R4 pointer reset
      wr(A_CTL, 8'h10);
      for (int k = 0; k < 9; k++) begin
         wr(A_DAT, 8'(8'hC0 + k));
         shadow[k % 8] = 8'(8'hC0 + k);
      end
      rd(A_PTR, v); chk("R5 pointer wraps", v, 8'h01);
      wr(A_CTL, 8'h10);
      rd(A_PTR, v); chk("R4 pointer cleared", v, 8'h00);
      rd(A_DAT, v); chk("R5 read slot0", v, 8'hC8);
      rd(A_PTR, v); chk("R5 read advances", v, 8'h01);
      check_store("R5 store contents");

      for (int tx = 0; tx < 8; tx++)
         for (int rx = 0; rx < 4; rx++)
            run_cmd(8'(8'h06 + tx * 8 + rx), tx, rx, 1'b1, 1'b0);

      run_cmd(8'hC7, 0, 0, 1'b1, 1'b0);
      run_cmd(8'h9F, 1, 1, 1'b1, 1'b1);
      wr(A_CTL, 8'h10); wr(A_DAT, 8'h00); wr(A_DAT, 8'h00); wr(A_DAT, 8'h00);
      shadow[0] = 8'h00; shadow[1] = 8'h00; shadow[2] = 8'h00;
      run_cmd(8'h05, 0, 2, 1'b0, 1'b0);
      run_cmd(8'h90, 3, 5, 1'b1, 1'b0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule